// File: doc/BRIEF.md
# Guarded Byte Memory Write Controller

This block sits between a simple single-cycle CPU register bus and a byte-wide nonvolatile data store. Software reaches it through four registers: an address register, a data register, a control register, and a write-only key register. A read copies the addressed byte into the data register in the cycle that follows the request. A write commits the data register to the addressed location after a busy period of `WR_CYCLES` clocks. At the end of that period a sticky completion flag is set and drives the `irq` output.

Writes are guarded. A write-start request succeeds only when both of these hold. First, the two bus accesses just before it were the key writes 55h and then AAh to the key register. Second, the write-enable bit was already set by an earlier bus write. A rejected start request sets an error bit. The store is a behavioural array that comes out of reset erased (every byte FFh). Bus reads return data combinationally on `bus_rdata` for whatever `bus_addr` selects. A read with `bus_valid` high also counts as a bus access.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: A control write (offset 2) with bit 0 = 1 and bit 7 = 0, made while no write is busy, loads the byte at the address register (offset 0) into the data register (offset 1), where it is visible right after that clock edge. An erased byte reads FFh. After reset, offsets 0, 1, 2 and 3 all read 00h and `irq` is 0.
- R2: The data register changes only on such a read or on a bus write to offset 1. Changing the address register leaves it unchanged.
- R3: A write starts only if the two bus accesses just before the starting control write were a write of 55h to offset 3 and then a write of AAh to offset 3. Any other value, or any intervening access (reads included), cancels the sequence. It must be repeated for every byte.
- R4: Control bit 1 starts a write only if control bit 2 (write enable) was already 1 before that bus write. Setting both bits in one write is rejected. A rejected start sets control bit 3 (error). Writing 0 to bit 3 clears it.
- R5: Write enable (control bit 2) is changed only by software writes to the control register. Hardware never clears it.
- R6: Clearing write enable while a write is busy neither aborts nor alters that write.
- R7: Control bit 1 reads 1 for exactly `WR_CYCLES` cycles after the starting edge. Writing 0 to it while busy has no effect.
- R8: When the busy period ends, control bit 1 returns to 0, control bit 4 (done) and `irq` become 1, and the store holds the new byte. Before that edge the store is unchanged.
- R9: The done bit stays 1 until software writes 0 to bit 4. Writing 1 to bit 4 never sets it.
- R10: A read request made while a write is busy is ignored, and the data register keeps its value.
- R11: With control bit 7 (other-memory select) written as 1, a read request is ignored and a write-start request is rejected with the error bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register offset: 0 address, 1 data, 2 control, 3 key |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Write-complete flag (control bit 4) |

## Verification
On every cycle, the assertions check the following. A busy period starts only from an armed key sequence with write enable already set. Write enable and the done flag fall only on a matching software write. Busy never ends early and never exceeds `WR_CYCLES`. The data register holds still while a write is busy. Only the bench's scenarios can show the rest: the byte actually read back after a write, rejection for each broken key pattern and for a combined enable-and-start write, the effect of the memory select bit, and that clearing write enable mid-write still commits the byte.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;
    localparam logic [1:0] OFS_KEY  = 2'd3;

    localparam int BIT_RD   = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_WEN  = 2;
    localparam int BIT_ERR  = 3;
    localparam int BIT_DONE = 4;
    localparam int BIT_MSEL = 7;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
    localparam logic [7:0] ERASED     = 8'hFF;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_FIRST = 2'd1,
        KS_ARMED = 2'd2
    } key_state_e;
endpackage

// File: rtl/nvm_unlock_seq.sv
module nvm_unlock_seq
    import nvm_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       armed
);
    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (access) begin
            if (key_wr && key_val == KEY_FIRST) begin
                state_d = KS_FIRST;
            end else if (key_wr && key_val == KEY_SECOND && state_q == KS_FIRST) begin
                state_d = KS_ARMED;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == KS_ARMED);
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.busy && (tmr_q.cnt == LAST);
        if (tmr_q.busy) begin
            if (done) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array
    import nvm_guard_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= ERASED;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
    import nvm_guard_pkg::*;
#(
    parameter int AW        = 8,
    parameter int WR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          wen;
        logic          msel;
        logic          err;
        logic          done;
        logic [AW-1:0] pend_addr;
        logic [7:0]    pend_data;
    } regs_t;

    regs_t regs_d, regs_q;

    logic       armed;
    logic       busy;
    logic       wr_done;
    logic       wr_start;
    logic [7:0] mem_rdata;
    logic       bus_wr;
    logic       ctrl_wr;

    assign bus_wr  = bus_valid && bus_write;
    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);

    nvm_unlock_seq u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (bus_valid),
        .key_wr  (bus_wr && (bus_addr == OFS_KEY)),
        .key_val (bus_wdata),
        .armed   (armed)
    );

    nvm_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_start),
        .busy  (busy),
        .done  (wr_done)
    );

    nvm_byte_array #(.AW(AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_done),
        .waddr (regs_q.pend_addr),
        .wdata (regs_q.pend_data),
        .raddr (regs_q.addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        regs_d   = regs_q;
        wr_start = 1'b0;

        if (bus_wr && bus_addr == OFS_ADDR) regs_d.addr = bus_wdata[AW-1:0];
        if (bus_wr && bus_addr == OFS_DATA) regs_d.data = bus_wdata;

        if (ctrl_wr) begin
            regs_d.wen  = bus_wdata[BIT_WEN];
            regs_d.msel = bus_wdata[BIT_MSEL];
            if (!bus_wdata[BIT_ERR])  regs_d.err  = 1'b0;
            if (!bus_wdata[BIT_DONE]) regs_d.done = 1'b0;
            if (bus_wdata[BIT_WR] && !busy) begin
                if (armed && regs_q.wen && !bus_wdata[BIT_MSEL]) wr_start = 1'b1;
                else                                             regs_d.err = 1'b1;
            end
            if (bus_wdata[BIT_RD] && !bus_wdata[BIT_MSEL] && !busy) begin
                regs_d.data = mem_rdata;
            end
        end

        if (wr_start) begin
            regs_d.pend_addr = regs_q.addr;
            regs_d.pend_data = regs_q.data;
        end

        if (wr_done) regs_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_ADDR: bus_rdata = 8'(regs_q.addr);
            OFS_DATA: bus_rdata = regs_q.data;
            OFS_CTRL: bus_rdata = {regs_q.msel, 2'b00, regs_q.done, regs_q.err,
                                   regs_q.wen, busy, 1'b0};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = regs_q.done;
endmodule

// File: rtl/nvm_guard_chk.sv
module nvm_guard_chk
    import nvm_guard_pkg::*;
#(
    parameter int WR_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_write,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       armed,
    input logic       wen,
    input logic       busy,
    input logic       done_flag,
    input logic [7:0] data_reg,
    input logic       mem_we
);
    logic ctrl_wr, data_wr;
    int   busy_cnt;

    assign ctrl_wr = bus_valid && bus_write && bus_addr == OFS_CTRL;
    assign data_wr = bus_valid && bus_write && bus_addr == OFS_DATA;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed)); // R3
    AST_START_WEN_EARLIER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen)); // R4
    AST_WEN_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wen) |-> $past(ctrl_wr && !bus_wdata[BIT_WEN])); // R5
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < WR_CYCLES); // R7
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_cnt) == WR_CYCLES - 1); // R7
    AST_COMMIT_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done_flag && !busy); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(ctrl_wr && !bus_wdata[BIT_DONE])); // R9
    AST_DATA_KEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !data_wr) |=> $stable(data_reg)); // R10
endmodule

bind nvm_guard_ctrl nvm_guard_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .armed     (armed),
    .wen       (regs_q.wen),
    .busy      (busy),
    .done_flag (regs_q.done),
    .data_reg  (regs_q.data),
    .mem_we    (wr_done)
);

// File: tb/tb_nvm_guard_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_guard_ctrl;
    localparam int W = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] mem_m [256];

    always #2.5 clk = ~clk;

    nvm_guard_ctrl #(.AW(8), .WR_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] ctrl_exp(input logic done, input logic err,
                                            input logic wen, input logic busy);
        return {3'b000, done, err, wen, busy, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic br(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        logic [7:0] v;
        bw(2'd0, a);
        bw(2'd2, 8'h01);
        peek(2'd1, v);
        chk(tag, v, mem_m[a]);
    endtask

    task automatic arm_and_start(input logic [7:0] a, input logic [7:0] d);
        bw(2'd0, a);
        bw(2'd1, d);
        bw(2'd2, 8'h04);
        bw(2'd3, 8'h55);
        bw(2'd3, 8'hAA);
        bw(2'd2, 8'h06);
    endtask

    task automatic good_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] v;
        arm_and_start(a, d);
        repeat (W - 1) @(posedge clk);
        #1;
        peek(2'd2, v);
        chk("R7 busy before end", v, ctrl_exp(1'b0, 1'b0, 1'b1, 1'b1));
        chk("R8 irq low while busy", {7'd0, irq}, 8'd0);
        @(posedge clk); #1;
        peek(2'd2, v);
        chk("R8 done after end", v, ctrl_exp(1'b1, 1'b0, 1'b1, 1'b0));
        chk("R8 irq at end", {7'd0, irq}, 8'd1);
        mem_m[a] = d;
        bw(2'd2, 8'h04);
        chk("R9 irq cleared", {7'd0, irq}, 8'd0);
    endtask

    task automatic expect_reject(input string tag);
        logic [7:0] v;
        peek(2'd2, v);
        chk(tag, v, ctrl_exp(1'b0, 1'b1, 1'b1, 1'b0));
        bw(2'd2, 8'h04);
        peek(2'd2, v);
        chk("R4 err cleared", v, ctrl_exp(1'b0, 1'b0, 1'b1, 1'b0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got 00 expected 01");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] a;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            peek(2'(r), v);
            chk("R1 reset reg", v, 8'h00);
        end
        chk("R1 reset irq", {7'd0, irq}, 8'd0);

        do_read(8'h05, "R1 erased read");

        good_write(8'h05, 8'h3C);
        do_read(8'h05, "R8 readback");

        // R9 done sticky and not settable
        arm_and_start(8'h06, 8'h11);
        repeat (W) @(posedge clk);
        #1;
        mem_m[8'h06] = 8'h11;
        bw(2'd2, 8'h14);
        peek(2'd2, v);
        chk("R9 done kept on write 1", v, ctrl_exp(1'b1, 1'b0, 1'b1, 1'b0));
        chk("R5 wen kept after write", v[2] ? 8'd1 : 8'd0, 8'd1);
        bw(2'd2, 8'h04);
        bw(2'd2, 8'h14);
        peek(2'd2, v);
        chk("R9 done not settable", v, ctrl_exp(1'b0, 1'b0, 1'b1, 1'b0));

        // R3 sequence needed per byte
        bw(2'd2, 8'h06);
        expect_reject("R3 no repeat of keys");

        // R2 data hold
        do_read(8'h05, "R2 read before hold");
        bw(2'd0, 8'h09);
        repeat (5) @(posedge clk);
        #1 peek(2'd1, v);
        chk("R2 data held", v, 8'h3C);
        bw(2'd1, 8'h77);
        peek(2'd1, v);
        chk("R2 software write", v, 8'h77);

        // R6 R7 R10: clear wen and try wr clear / read while busy
        arm_and_start(8'h09, 8'h5A);
        bw(2'd2, 8'h00);
        peek(2'd2, v);
        chk("R7 wr bit not cleared by sw, R6 wen off", v, ctrl_exp(1'b0, 1'b0, 1'b0, 1'b1));
        bw(2'd2, 8'h01);
        peek(2'd1, v);
        chk("R10 read ignored while busy", v, 8'h5A);
        repeat (W - 3) @(posedge clk);
        #1 peek(2'd2, v);
        chk("R6 still busy", v, ctrl_exp(1'b0, 1'b0, 1'b0, 1'b1));
        @(posedge clk); #1;
        peek(2'd2, v);
        chk("R6 completes", v, ctrl_exp(1'b1, 1'b0, 1'b0, 1'b0));
        mem_m[8'h09] = 8'h5A;
        bw(2'd2, 8'h00);
        do_read(8'h09, "R6 byte committed");

        // R11 other memory select
        do_read(8'h05, "R11 prep");
        bw(2'd0, 8'h09);
        bw(2'd2, 8'h81);
        peek(2'd1, v);
        chk("R11 read ignored", v, 8'h3C);
        peek(2'd2, v);
        chk("R11 ctrl msel", v, 8'h80);
        bw(2'd2, 8'h84);
        bw(2'd3, 8'h55);
        bw(2'd3, 8'hAA);
        bw(2'd2, 8'h86);
        peek(2'd2, v);
        chk("R11 start rejected", v, 8'h8C);
        bw(2'd2, 8'h04);
        repeat (W + 2) @(posedge clk);
        #1;
        do_read(8'h09, "R11 memory unchanged");

        // R4 both bits in one write
        bw(2'd2, 8'h00);
        bw(2'd3, 8'h55);
        bw(2'd3, 8'hAA);
        bw(2'd2, 8'h06);
        expect_reject("R4 same-write enable");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom_range(0, 4));
            a = 8'($urandom);
            d = 8'($urandom);
            case (op)
                0: good_write(a, d);
                1: begin
                    logic [7:0] bad;
                    bad = 8'($urandom);
                    if (bad == 8'hAA || bad == 8'h55) bad = 8'h00;
                    bw(2'd0, a); bw(2'd1, d); bw(2'd2, 8'h04);
                    bw(2'd3, 8'h55); bw(2'd3, bad); bw(2'd2, 8'h06);
                    expect_reject("R3 wrong key");
                    repeat (W) @(posedge clk);
                    do_read(a, "R3 wrong key memory");
                end
                2: begin
                    logic [7:0] dummy;
                    bw(2'd0, a); bw(2'd1, d); bw(2'd2, 8'h04);
                    bw(2'd3, 8'h55);
                    if ($urandom_range(0, 1) == 1) begin
                        br(2'd0, dummy); bw(2'd3, 8'hAA);
                    end else begin
                        bw(2'd3, 8'hAA); br(2'd1, dummy);
                    end
                    bw(2'd2, 8'h06);
                    expect_reject("R3 intervening access");
                    repeat (W) @(posedge clk);
                    do_read(a, "R3 intervening memory");
                end
                3: begin
                    bw(2'd0, a); bw(2'd1, d); bw(2'd2, 8'h00);
                    bw(2'd3, 8'h55); bw(2'd3, 8'hAA); bw(2'd2, 8'h06);
                    expect_reject("R4 enable not earlier");
                    repeat (W) @(posedge clk);
                    do_read(a, "R4 memory unchanged");
                end
                default: do_read(a, "R1 random read");
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule